// File: doc/BRIEF.md
# Machine Check Bank Logger

This block keeps the error-recording state of a processor's machine-check architecture. It holds a set of per-bank error records and three global registers: capability, control and status. Each bank record has four 64-bit fields: control, status, address and miscellaneous. An error-injection event carries a bank number, a 64-bit status word, a global-status word, an address, a miscellaneous word and an unconditional flag. The block evaluates the event in the cycle it arrives. Depending on the error's severity and the current state, it logs the event, overwrites the bank, marks an overflow, drops it, ignores it, or asks for a processor reset.

Software-side logic reads and writes every register through a simple single-cycle port. The read data path is combinational. A logged uncorrected error raises a one-cycle machine-check interrupt. An uncorrected error that cannot be delivered raises a one-cycle reset request instead.

The register map is as follows. Address 0 is capability, 1 is global control and 2 is global status. Bank `i` occupies addresses 4+4i to 7+4i, holding control, status, address and miscellaneous in that order.

Top module: `mcb_logger`

## Requirements
- R1: After reset every register reads zero except capability, which reads the bank count in bits [7:0] with bit 8 (global-control-present) set. `mce_irq` and `reset_req` are low.
- R2: A write on the register port updates the addressed register at the next clock edge, and reads return it combinationally. Address 3 and addresses beyond the last bank read zero.
- R3: An event is rejected with no state change and no pulse if the capability is zero, if the bank number is not below capability bits [7:0] or the built bank count, or if status bit 63 (valid) is clear.
- R4: An uncorrected event (status bit 61 set) is dropped without effect if the bank control is not all ones. It is also dropped if capability bit 8 is set and global control is not all ones. When capability bit 8 is clear, global control is not consulted.
- R5: An uncorrected event that passes R4 requests a reset instead of logging when global status bit 2 (in-progress) is already set or when `mce_enable` is low. No register changes.
- R6: A logged uncorrected event writes the bank status, address and miscellaneous fields and loads global status from the event. Status bit 62 (overflow) is set when the old bank status was valid. `mce_irq` pulses.
- R7: A corrected event overwrites the bank status, address and miscellaneous fields when the old status is not valid or not uncorrected. Bit 62 is set when the old status was valid. No interrupt is raised.
- R8: A corrected event that meets a valid uncorrected bank entry leaves the entry in place and only sets its bit 62.
- R9: An event whose status bit 55 (action-required) is clear is ignored while global status bit 2 is set, unless `inj_uncond` is high. Action-required events are not ignored.
- R10: `mce_irq` and `reset_req` come from registers. Each is high for exactly the one cycle after the deciding edge, and they are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| mce_enable | input | 1 | Machine checks enabled by the operating system |
| inj_valid | input | 1 | Injection event present this cycle |
| inj_bank | input | 8 | Target bank number |
| inj_status | input | 64 | Status word for the bank |
| inj_gstatus | input | 64 | Global status to load when an uncorrected error is logged |
| inj_addr | input | 64 | Error address |
| inj_misc | input | 64 | Extra error information |
| inj_uncond | input | 1 | Log even while a previous check is in progress |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W (5) | Register address |
| reg_wdata | input | 64 | Register write data |
| reg_rdata | output | 64 | Register read data (combinational) |
| mce_irq | output | 1 | One-cycle machine-check interrupt |
| reset_req | output | 1 | One-cycle reset request |

## Verification
A wrong decision shows up at the edge that applies the event. One cycle later it appears as a missing, extra or doubled pulse on `mce_irq` or `reset_req`. It also appears as a bank status whose overflow or valid bit differs from the one expected when that register is read back. A corrupted global in-progress bit or control value stays hidden until the next event. That event is then ignored, dropped or escalated to reset wrongly, so each scenario re-reads the affected register straight after the event it should or should not have changed.

// File: rtl/mcb_pkg.sv
package mcb_pkg;
  localparam int DW       = 64;
  localparam int IDX_W    = 8;
  localparam int VAL_BIT  = 63;
  localparam int OVER_BIT = 62;
  localparam int UC_BIT   = 61;
  localparam int AR_BIT   = 55;
  localparam int MCIP_BIT = 2;
  localparam int CTLP_BIT = 8;
  localparam int GLOBAL_SLOTS = 4;
  localparam int FIELDS       = 4;

  typedef logic [DW-1:0] word_t;

  typedef enum logic [2:0] {
    ACT_NONE,
    ACT_REJECT,
    ACT_IGNORE,
    ACT_DROP,
    ACT_RESET,
    ACT_LOG_UC,
    ACT_LOG_CE,
    ACT_SET_OVER
  } mcb_act_e;
endpackage

// File: rtl/mcb_decide.sv
module mcb_decide
  import mcb_pkg::*;
#(
  parameter int NUM_BANKS = 4
) (
  input  logic             valid,
  input  logic [IDX_W-1:0] bank,
  input  word_t            status,
  input  logic             uncond,
  input  logic             mce_en,
  input  word_t            cap,
  input  word_t            gctl,
  input  word_t            gstatus,
  input  word_t            sel_ctl,
  input  word_t            sel_status,
  output mcb_act_e         act,
  output word_t            new_status
);
  logic in_range;
  logic accepted;
  logic recursive;
  logic gctl_blocks;
  logic old_val;
  logic old_uc;

  assign in_range    = ({1'b0, bank} < (IDX_W+1)'(NUM_BANKS)) && (bank < cap[IDX_W-1:0]);
  assign accepted    = (cap != '0) && in_range && status[VAL_BIT];
  assign recursive   = gstatus[MCIP_BIT];
  assign gctl_blocks = cap[CTLP_BIT] && (gctl != '1);
  assign old_val     = sel_status[VAL_BIT];
  assign old_uc      = sel_status[UC_BIT];

  always_comb begin
    act        = ACT_NONE;
    new_status = status;
    if (valid) begin
      if (!accepted) begin
        act = ACT_REJECT;
      end else if (!uncond && !status[AR_BIT] && recursive) begin
        act = ACT_IGNORE;
      end else if (status[UC_BIT]) begin
        if (gctl_blocks || (sel_ctl != '1)) begin
          act = ACT_DROP;
        end else if (recursive || !mce_en) begin
          act = ACT_RESET;
        end else begin
          act = ACT_LOG_UC;
          new_status[OVER_BIT] = status[OVER_BIT] | old_val;
        end
      end else if (!old_val || !old_uc) begin
        act = ACT_LOG_CE;
        new_status[OVER_BIT] = status[OVER_BIT] | old_val;
      end else begin
        act = ACT_SET_OVER;
      end
    end
  end
endmodule

// File: rtl/mcb_bank.sv
module mcb_bank
  import mcb_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [FIELDS-1:0] sw_we,
  input  word_t             sw_wdata,
  input  logic              log_en,
  input  logic              over_en,
  input  word_t             new_status,
  input  word_t             new_addr,
  input  word_t             new_misc,
  output word_t             ctl_q,
  output word_t             status_q,
  output word_t             addr_q,
  output word_t             misc_q
);
  word_t ctl_d, status_d, addr_d, misc_d;
  logic  en;

  assign en = (|sw_we) | log_en | over_en;

  always_comb begin
    ctl_d    = ctl_q;
    status_d = status_q;
    addr_d   = addr_q;
    misc_d   = misc_q;
    if (sw_we[0]) ctl_d    = sw_wdata;
    if (sw_we[1]) status_d = sw_wdata;
    if (sw_we[2]) addr_d   = sw_wdata;
    if (sw_we[3]) misc_d   = sw_wdata;
    // an injection outranks a software write in the same cycle
    if (log_en) begin
      status_d = new_status;
      addr_d   = new_addr;
      misc_d   = new_misc;
    end else if (over_en) begin
      status_d = status_q;
      status_d[OVER_BIT] = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q    <= '0;
      status_q <= '0;
      addr_q   <= '0;
      misc_q   <= '0;
    end else if (en) begin
      ctl_q    <= ctl_d;
      status_q <= status_d;
      addr_q   <= addr_d;
      misc_q   <= misc_d;
    end
  end
endmodule

// File: rtl/mcb_global.sv
module mcb_global
  import mcb_pkg::*;
#(
  parameter int NUM_BANKS = 4
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  we_cap,
  input  logic  we_gctl,
  input  logic  we_gstatus,
  input  word_t wdata,
  input  logic  load_gstatus,
  input  word_t new_gstatus,
  output word_t cap_q,
  output word_t gctl_q,
  output word_t gstatus_q
);
  localparam word_t CAP_RESET = DW'(NUM_BANKS) | (word_t'(1) << CTLP_BIT);

  word_t cap_d, gctl_d, gstatus_d;
  logic  en;

  assign en = we_cap | we_gctl | we_gstatus | load_gstatus;

  always_comb begin
    cap_d     = cap_q;
    gctl_d    = gctl_q;
    gstatus_d = gstatus_q;
    if (we_cap)     cap_d     = wdata;
    if (we_gctl)    gctl_d    = wdata;
    if (we_gstatus) gstatus_d = wdata;
    if (load_gstatus) gstatus_d = new_gstatus;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap_q     <= CAP_RESET;
      gctl_q    <= '0;
      gstatus_q <= '0;
    end else if (en) begin
      cap_q     <= cap_d;
      gctl_q    <= gctl_d;
      gstatus_q <= gstatus_d;
    end
  end
endmodule

// File: rtl/mcb_logger.sv
module mcb_logger
  import mcb_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  localparam int ADDR_W = $clog2(FIELDS * (NUM_BANKS + 1))
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mce_enable,
  input  logic              inj_valid,
  input  logic [IDX_W-1:0]  inj_bank,
  input  logic [DW-1:0]     inj_status,
  input  logic [DW-1:0]     inj_gstatus,
  input  logic [DW-1:0]     inj_addr,
  input  logic [DW-1:0]     inj_misc,
  input  logic              inj_uncond,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DW-1:0]     reg_wdata,
  output logic [DW-1:0]     reg_rdata,
  output logic              mce_irq,
  output logic              reset_req
);
  localparam int BIDX_W = ADDR_W - 2;

  // reset: asserted at once, removed on a clock edge
  logic [1:0] rst_pipe;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  word_t cap_q, gctl_q, gstatus_q;
  word_t bk_ctl    [NUM_BANKS];
  word_t bk_status [NUM_BANKS];
  word_t bk_addr   [NUM_BANKS];
  word_t bk_misc   [NUM_BANKS];

  word_t    sel_ctl, sel_status, new_status;
  mcb_act_e act;

  // registers of the bank the event targets
  always_comb begin
    sel_ctl    = '0;
    sel_status = '0;
    for (int i = 0; i < NUM_BANKS; i++) begin
      if (inj_bank == IDX_W'(i)) begin
        sel_ctl    = bk_ctl[i];
        sel_status = bk_status[i];
      end
    end
  end

  mcb_decide #(.NUM_BANKS(NUM_BANKS)) u_decide (
    .valid      (inj_valid),
    .bank       (inj_bank),
    .status     (inj_status),
    .uncond     (inj_uncond),
    .mce_en     (mce_enable),
    .cap        (cap_q),
    .gctl       (gctl_q),
    .gstatus    (gstatus_q),
    .sel_ctl    (sel_ctl),
    .sel_status (sel_status),
    .act        (act),
    .new_status (new_status)
  );

  logic log_any;
  assign log_any = (act == ACT_LOG_UC) || (act == ACT_LOG_CE);

  mcb_global #(.NUM_BANKS(NUM_BANKS)) u_global (
    .clk          (clk),
    .rst_n        (rst_sync_n),
    .we_cap       (reg_wr && (reg_addr == ADDR_W'(0))),
    .we_gctl      (reg_wr && (reg_addr == ADDR_W'(1))),
    .we_gstatus   (reg_wr && (reg_addr == ADDR_W'(2))),
    .wdata        (reg_wdata),
    .load_gstatus (act == ACT_LOG_UC),
    .new_gstatus  (inj_gstatus),
    .cap_q        (cap_q),
    .gctl_q       (gctl_q),
    .gstatus_q    (gstatus_q)
  );

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic [FIELDS-1:0] we;
    logic              hit;
    for (genvar f = 0; f < FIELDS; f++) begin : g_we
      assign we[f] = reg_wr && (reg_addr == ADDR_W'(FIELDS * (b + 1) + f));
    end
    assign hit = (inj_bank == IDX_W'(b));

    mcb_bank u_bank (
      .clk        (clk),
      .rst_n      (rst_sync_n),
      .sw_we      (we),
      .sw_wdata   (reg_wdata),
      .log_en     (hit && log_any),
      .over_en    (hit && (act == ACT_SET_OVER)),
      .new_status (new_status),
      .new_addr   (inj_addr),
      .new_misc   (inj_misc),
      .ctl_q      (bk_ctl[b]),
      .status_q   (bk_status[b]),
      .addr_q     (bk_addr[b]),
      .misc_q     (bk_misc[b])
    );
  end

  // read mux
  logic [ADDR_W-1:0] rd_off;
  logic [BIDX_W-1:0] rd_bidx;
  assign rd_off  = reg_addr - ADDR_W'(GLOBAL_SLOTS);
  assign rd_bidx = rd_off[ADDR_W-1:2];

  always_comb begin
    reg_rdata = '0;
    if (reg_addr < ADDR_W'(GLOBAL_SLOTS)) begin
      case (reg_addr[1:0])
        2'd0:    reg_rdata = cap_q;
        2'd1:    reg_rdata = gctl_q;
        2'd2:    reg_rdata = gstatus_q;
        default: reg_rdata = '0;
      endcase
    end else begin
      for (int i = 0; i < NUM_BANKS; i++) begin
        if (rd_bidx == BIDX_W'(i)) begin
          case (rd_off[1:0])
            2'd0:    reg_rdata = bk_ctl[i];
            2'd1:    reg_rdata = bk_status[i];
            2'd2:    reg_rdata = bk_addr[i];
            default: reg_rdata = bk_misc[i];
          endcase
        end
      end
    end
  end

  // pulse outputs
  logic irq_d, rst_req_d, pulse_en;
  assign irq_d     = (act == ACT_LOG_UC);
  assign rst_req_d = (act == ACT_RESET);
  assign pulse_en  = irq_d | rst_req_d | mce_irq | reset_req;

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      mce_irq   <= 1'b0;
      reset_req <= 1'b0;
    end else if (pulse_en) begin
      mce_irq   <= irq_d;
      reset_req <= rst_req_d;
    end
  end
endmodule

// File: rtl/mcb_logger_chk.sv
module mcb_logger_chk
  import mcb_pkg::*;
(
  input logic  clk,
  input logic  rst_n,
  input logic  inj_valid,
  input word_t inj_status,
  input word_t inj_gstatus,
  input logic  inj_uncond,
  input logic  mce_irq,
  input logic  reset_req,
  input word_t gstatus_q
);
  // R10
  pulse_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(mce_irq && reset_req));

  // R10
  pulse_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mce_irq || reset_req) |-> $past(inj_valid));

  // R6
  irq_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mce_irq |-> ($past(inj_status[UC_BIT]) && (gstatus_q == $past(inj_gstatus))));

  // R5
  reset_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reset_req |-> ($past(inj_status[UC_BIT]) && $stable(gstatus_q)));

  // R3
  reject_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (inj_valid && !inj_status[VAL_BIT]) |=> (!mce_irq && !reset_req));

  // R9
  ignore_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (inj_valid && !inj_status[AR_BIT] && gstatus_q[MCIP_BIT] && !inj_uncond)
      |=> (!mce_irq && !reset_req));
endmodule

bind mcb_logger mcb_logger_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_sync_n),
  .inj_valid   (inj_valid),
  .inj_status  (inj_status),
  .inj_gstatus (inj_gstatus),
  .inj_uncond  (inj_uncond),
  .mce_irq     (mce_irq),
  .reset_req   (reset_req),
  .gstatus_q   (gstatus_q)
);

// File: tb/mcb_logger_test.sv
module mcb_logger_test;
  localparam logic [1:0]  KW = 2'd0;  // register write
  localparam logic [1:0]  KI = 2'd1;  // injection
  localparam logic [1:0]  KR = 2'd2;  // read only
  localparam logic [63:0] ONES = 64'hFFFF_FFFF_FFFF_FFFF;
  localparam logic [63:0] Z    = 64'h0;

  typedef struct packed {
    logic [1:0]  kind;
    logic [4:0]  ra;
    logic [7:0]  bank;
    logic [63:0] dat;
    logic [63:0] gst;
    logic [63:0] adr;
    logic        unc;
    logic        men;
    logic        eirq;
    logic        erst;
    logic [63:0] ev;
    logic [7:0]  tag;
  } vec_t;

  localparam int NV = 34;
  localparam vec_t TBL [NV] = '{
    '{KW, 5'd1,  8'd0, ONES, Z, Z, 1'b0, 1'b1, 1'b0, 1'b0, ONES, 8'd2},                                   // R2 gctl
    '{KW, 5'd4,  8'd0, ONES, Z, Z, 1'b0, 1'b1, 1'b0, 1'b0, ONES, 8'd2},                                   // R2 bank0 ctl
    '{KI, 5'd5,  8'd0, 64'hA000_0000_0000_0011, 64'h5, 64'h1000, 1'b0, 1'b1, 1'b1, 1'b0,
      64'hA000_0000_0000_0011, 8'd6},                                                                     // R6 first UC
    '{KR, 5'd2,  8'd0, Z, Z, Z, 1'b0, 1'b1, 1'b0, 1'b0, 64'h5, 8'd6},                                     // R6 gstatus
    '{KR, 5'd7,  8'd0, Z, Z, Z, 1'b0, 1'b1, 1'b0, 1'b0, 64'hFFFF_FFFF_FFFF_EFFF, 8'd6},                   // R6 misc
    '{KI, 5'd9,  8'd1, 64'h8000_0000_0000_0022, Z, 64'h2000, 1'b0, 1'b1, 1'b0, 1'b0, Z, 8'd9},           // R9 ignored
    '{KI, 5'd9,  8'd1, 64'h8000_0000_0000_0022, Z, 64'h2000, 1'b1, 1'b1, 1'b0, 1'b0,
      64'h8000_0000_0000_0022, 8'd9},                                                                     // R9 uncond
    '{KW, 5'd2,  8'd0, Z, Z, Z, 1'b0, 1'b1, 1'b0, 1'b0, Z, 8'd2},                                         // R2 clear gstatus
    '{KI, 5'd9,  8'd1, 64'h8000_0000_0000_0033, Z, 64'h3000, 1'b0, 1'b1, 1'b0, 1'b0,
      64'hC000_0000_0000_0033, 8'd7},                                                                     // R7 overwrite + over
    '{KR, 5'd10, 8'd0, Z, Z, Z, 1'b0, 1'b1, 1'b0, 1'b0, 64'h3000, 8'd7},                                  // R7 address
    '{KI, 5'd5,  8'd0, 64'h8000_0000_0000_0044, Z, 64'h9999, 1'b0, 1'b1, 1'b0, 1'b0,
      64'hE000_0000_0000_0011, 8'd8},                                                                     // R8 keep UC
    '{KR, 5'd6,  8'd0, Z, Z, Z, 1'b0, 1'b1, 1'b0, 1'b0, 64'h1000, 8'd8},                                  // R8 addr kept
    '{KI, 5'd13, 8'd2, 64'hA000_0000_0000_0055, Z, Z, 1'b0, 1'b1, 1'b0, 1'b0, Z, 8'd4},                   // R4 bank ctl
    '{KW, 5'd1,  8'd0, 64'hFFFF_FFFF_FFFF_FFFE, Z, Z, 1'b0, 1'b1, 1'b0, 1'b0,
      64'hFFFF_FFFF_FFFF_FFFE, 8'd2},                                                                     // R2
    '{KI, 5'd5,  8'd0, 64'hA000_0000_0000_0055, Z, Z, 1'b0, 1'b1, 1'b0, 1'b0,
      64'hE000_0000_0000_0011, 8'd4},                                                                     // R4 gctl
    '{KW, 5'd1,  8'd0, ONES, Z, Z, 1'b0, 1'b1, 1'b0, 1'b0, ONES, 8'd2},                                   // R2
    '{KI, 5'd5,  8'd0, 64'hA000_0000_0000_0066, Z, Z, 1'b0, 1'b0, 1'b0, 1'b1,
      64'hE000_0000_0000_0011, 8'd5},                                                                     // R5 disabled
    '{KW, 5'd2,  8'd0, 64'h4, Z, Z, 1'b0, 1'b1, 1'b0, 1'b0, 64'h4, 8'd2},                                 // R2 set in-progress
    '{KI, 5'd2,  8'd0, 64'hA080_0000_0000_0066, Z, Z, 1'b0, 1'b1, 1'b0, 1'b1, 64'h4, 8'd5},               // R5 recursive AR
    '{KW, 5'd2,  8'd0, Z, Z, Z, 1'b0, 1'b1, 1'b0, 1'b0, Z, 8'd2},                                         // R2
    '{KI, 5'd5,  8'd0, 64'hA000_0000_0000_0077, 64'h4, 64'h7000, 1'b0, 1'b1, 1'b1, 1'b0,
      64'hE000_0000_0000_0077, 8'd6},                                                                     // R6 over
    '{KR, 5'd2,  8'd0, Z, Z, Z, 1'b0, 1'b1, 1'b0, 1'b0, 64'h4, 8'd6},                                     // R6
    '{KI, 5'd5,  8'd0, 64'hA000_0000_0000_0088, Z, Z, 1'b0, 1'b1, 1'b0, 1'b0,
      64'hE000_0000_0000_0077, 8'd9},                                                                     // R9 UC ignored
    '{KW, 5'd0,  8'd0, 64'h103, Z, Z, 1'b0, 1'b1, 1'b0, 1'b0, 64'h103, 8'd2},                             // R2 cap
    '{KI, 5'd17, 8'd3, 64'h8000_0000_0000_0099, Z, 64'hAA, 1'b1, 1'b1, 1'b0, 1'b0, Z, 8'd3},              // R3 bank range
    '{KW, 5'd0,  8'd0, Z, Z, Z, 1'b0, 1'b1, 1'b0, 1'b0, Z, 8'd2},                                         // R2
    '{KI, 5'd13, 8'd2, 64'h8000_0000_0000_0099, Z, 64'hAA, 1'b1, 1'b1, 1'b0, 1'b0, Z, 8'd3},              // R3 cap zero
    '{KW, 5'd0,  8'd0, 64'h104, Z, Z, 1'b0, 1'b1, 1'b0, 1'b0, 64'h104, 8'd2},                             // R2
    '{KI, 5'd13, 8'd2, 64'h0000_0000_0000_0099, Z, 64'hAA, 1'b1, 1'b1, 1'b0, 1'b0, Z, 8'd3},              // R3 not valid
    '{KI, 5'd13, 8'd2, 64'h8000_0000_0000_0099, Z, 64'hAA, 1'b1, 1'b1, 1'b0, 1'b0,
      64'h8000_0000_0000_0099, 8'd7},                                                                     // R7 fresh
    '{KW, 5'd0,  8'd0, 64'h004, Z, Z, 1'b0, 1'b1, 1'b0, 1'b0, 64'h004, 8'd2},                             // R2
    '{KW, 5'd1,  8'd0, Z, Z, Z, 1'b0, 1'b1, 1'b0, 1'b0, Z, 8'd2},                                         // R2
    '{KW, 5'd2,  8'd0, Z, Z, Z, 1'b0, 1'b1, 1'b0, 1'b0, Z, 8'd2},                                         // R2
    '{KI, 5'd5,  8'd0, 64'hA000_0000_0000_00AA, Z, 64'hB0, 1'b0, 1'b1, 1'b1, 1'b0,
      64'hE000_0000_0000_00AA, 8'd4}                                                                      // R4 no gctl
  };

  logic        clk = 1'b0;
  logic        rst_n;
  logic        mce_enable;
  logic        inj_valid;
  logic [7:0]  inj_bank;
  logic [63:0] inj_status, inj_gstatus, inj_addr, inj_misc;
  logic        inj_uncond;
  logic        reg_wr;
  logic [4:0]  reg_addr;
  logic [63:0] reg_wdata, reg_rdata;
  logic        mce_irq, reset_req;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  mcb_logger #(.NUM_BANKS(4)) uut (
    .clk(clk), .rst_n(rst_n), .mce_enable(mce_enable),
    .inj_valid(inj_valid), .inj_bank(inj_bank), .inj_status(inj_status),
    .inj_gstatus(inj_gstatus), .inj_addr(inj_addr), .inj_misc(inj_misc),
    .inj_uncond(inj_uncond), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .mce_irq(mce_irq), .reset_req(reset_req)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic read_chk(input string req, input logic [4:0] a, input logic [63:0] exp);
    reg_addr = a;
    #1;
    check(req, reg_rdata, exp);
  endtask

  task automatic run_vec(input vec_t v, input int n);
    string tg;
    tg = $sformatf("R%0d vec%0d", v.tag, n);
    @(negedge clk);
    mce_enable = v.men;
    case (v.kind)
      KW: begin
        reg_wr = 1'b1; reg_addr = v.ra; reg_wdata = v.dat;
      end
      KI: begin
        inj_valid = 1'b1; inj_bank = v.bank; inj_status = v.dat;
        inj_gstatus = v.gst; inj_addr = v.adr; inj_misc = ~v.adr;
        inj_uncond = v.unc;
      end
      default: ;
    endcase
    @(negedge clk);
    reg_wr = 1'b0;
    inj_valid = 1'b0;
    #1;
    check({tg, " irq"}, {63'd0, mce_irq}, {63'd0, v.eirq});
    check({tg, " rst"}, {63'd0, reset_req}, {63'd0, v.erst});
    read_chk({tg, " reg"}, v.ra, v.ev);
    @(negedge clk);
    #1;
    // R10: pulses last a single cycle
    check({"R10 ", tg}, {62'd0, mce_irq, reset_req}, 64'd0);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    rst_n = 1'b0; mce_enable = 1'b1; inj_valid = 1'b0; inj_bank = '0;
    inj_status = '0; inj_gstatus = '0; inj_addr = '0; inj_misc = '0;
    inj_uncond = 1'b0; reg_wr = 1'b0; reg_addr = '0; reg_wdata = '0;
    do_reset();
    // R1 reset state
    read_chk("R1 cap", 5'd0, 64'h104);
    read_chk("R1 gctl", 5'd1, 64'h0);
    read_chk("R1 gstatus", 5'd2, 64'h0);
    read_chk("R1 bank0 status", 5'd5, 64'h0);
    read_chk("R1 bank3 misc", 5'd19, 64'h0);
    check("R1 pulses", {62'd0, mce_irq, reset_req}, 64'd0);

    for (int i = 0; i < NV; i++) run_vec(TBL[i], i);

    // R2 unmapped addresses
    @(negedge clk);
    read_chk("R2 addr3", 5'd3, 64'h0);
    read_chk("R2 addr25", 5'd25, 64'h0);

    // R1 reset in mid-run restores defaults
    do_reset();
    read_chk("R1 after reset cap", 5'd0, 64'h104);
    read_chk("R1 after reset bank0 status", 5'd5, 64'h0);
    read_chk("R1 after reset bank0 ctl", 5'd4, 64'h0);

    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule